// File: doc/BRIEF.md
# Three-Port GPIO Bank with Open-Drain I2C Lines

This block holds three general-purpose I/O ports behind a small register bus. Two ports, A and B, are eight bits wide. Port C is four bits wide. Each port has a data register and a direction register. A direction bit of 1 makes that pin an output, and a direction bit of 0 makes it an input. Reading a port's data address returns a merge of two sources: the external level on each input pin and the latched data on each output pin. The driven value of every port, which is its data register ANDed with its direction register, is brought out continuously. Port C bit 3 also serves as the host-processor reset output. Port B bit 4 is the host serial clock output and port B bit 5 is the host serial data line.

Software can bit-bang an I2C bus through port B. It holds the data bit for the clock line at zero and toggles only direction bits 7 and 6. A set direction bit pulls its line low. A clear direction bit releases the line high. The block exports the resulting SCL and SDA levels. It also feeds an externally observed SDA level back into the port B read value. Port B bit 0 is wired as a constant "supply present" input.

Top module: `gpio3_i2c`

## Requirements
- R1: A read of a port's data address (bus_addr[2]=0, bus_addr[1:0]=0 for A, 1 for B, 2 for C) returns the port's external input bits masked by the inverted direction register, ORed with the data register masked by the direction register.
- R2: Each port's drive output equals its data register ANDed with its direction register. It takes the new value on the same clock edge that writes either register.
- R3: While port B data bit 7 holds 0, i2c_scl_o equals the inverse of port B direction bit 7 and i2c_sda_o equals the inverse of direction bit 6. These lines follow on the same edge as the register write.
- R4: While port B data bit 7 holds 1, i2c_scl_o and i2c_sda_o keep their last values, whatever is written to the direction register.
- R5: The external input seen by port B reads bit 0 as a constant 1, bit 6 as sda_in and bit 5 as host_sdata_in. Bits 7 and 4..1 come from pb_in.
- R6: Port C stores only four bits. Reads of its data or direction address return 0 in bits 7..4, and pc_drive is four bits wide.
- R7: host_reset_o equals pc_drive bit 3. The host serial clock output is pb_drive bit 4 and the host serial data output is pb_drive bit 5.
- R8: Address codes whose bus_addr[1:0] is 3 read as 0, and writes to them change no register or output.
- R9: A read of a direction address (bus_addr[2]=1, port in bus_addr[1:0]) returns that port's direction register.
- R10: After reset, every data and direction register is 0, all drive outputs are 0 and both I2C lines are released high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address: bit 2 selects direction, bits 1..0 select the port |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pa_in | input | 8 | Port A external pin levels |
| pb_in | input | 8 | Port B external pin levels (bits 0, 5 and 6 replaced) |
| pc_in | input | 4 | Port C external pin levels |
| sda_in | input | 1 | Observed I2C data line level |
| host_sdata_in | input | 1 | Observed host serial data line level |
| pa_drive | output | 8 | Port A data AND direction |
| pb_drive | output | 8 | Port B data AND direction |
| pc_drive | output | 4 | Port C data AND direction |
| host_reset_o | output | 1 | Host processor reset level |
| i2c_scl_o | output | 1 | I2C clock line level |
| i2c_sda_o | output | 1 | I2C data line level |

## Verification
The hardest case to reach is the hold behaviour of the I2C lines. It shows only when port B data bit 7 is 1 while the direction bits change, and software never sets up that order by accident. The stimulus first releases both lines, then sets data bit 7 and writes a direction value that would pull both lines low. It confirms that the lines stay released. It then clears data bit 7 and confirms that both lines drop on that same write. The forced read bits of port B are exercised against opposing pin levels on pb_in, so that each substituted source is distinguished from the raw pin.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;

  typedef enum logic [1:0] {
    PORT_A    = 2'd0,
    PORT_B    = 2'd1,
    PORT_C    = 2'd2,
    PORT_NONE = 2'd3
  } port_sel_e;

  // port B roles
  localparam int unsigned SCL_BIT    = 7;
  localparam int unsigned SDA_BIT    = 6;
  localparam int unsigned HSDATA_BIT = 5;
  localparam int unsigned HSCLK_BIT  = 4;
  localparam int unsigned SUPPLY_BIT = 0;
  // port C role
  localparam int unsigned HRST_BIT   = 3;

endpackage

// File: rtl/gpio3_rst_sync.sv
module gpio3_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio3_port_reg.sv
module gpio3_port_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_en,
  input  logic         wr_dir_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_nxt,
  output logic [W-1:0] dir_nxt
);
  always_comb begin
    data_nxt = data_q;
    dir_nxt  = dir_q;
    if (wr_data_en) data_nxt = wdata;
    if (wr_dir_en)  dir_nxt  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_en || wr_dir_en) begin
        data_q <= data_nxt;
        dir_q  <= dir_nxt;
      end
    end
  end
endmodule

// File: rtl/gpio3_i2c_line.sv
module gpio3_i2c_line
  import gpio3_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_nxt,
  input  logic [W-1:0] dir_nxt,
  output logic         scl,
  output logic         sda
);
  logic [1:0] line_q;
  logic [1:0] line_nxt;
  logic       line_en;

  // open-drain: lines follow the direction bits only while the clock data bit is 0
  always_comb begin
    line_en  = ~data_nxt[SCL_BIT];
    line_nxt = line_q;
    if (line_en) line_nxt = {~dir_nxt[SCL_BIT], ~dir_nxt[SDA_BIT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 2'b11;
    else if (line_en) line_q <= line_nxt;
  end

  assign scl = line_q[1];
  assign sda = line_q[0];
endmodule

// File: rtl/gpio3_read_mux.sv
module gpio3_read_mux #(
  parameter int unsigned NPORT = 3,
  parameter int unsigned W     = 8
) (
  input  logic [1:0]              port_idx,
  input  logic                    is_dir,
  input  logic [NPORT-1:0][W-1:0] data_q,
  input  logic [NPORT-1:0][W-1:0] dir_q,
  input  logic [NPORT-1:0][W-1:0] ext_in,
  output logic [W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (port_idx == 2'(p)) begin
        if (is_dir) rdata = dir_q[p];
        else        rdata = (ext_in[p] & ~dir_q[p]) | (data_q[p] & dir_q[p]);
      end
    end
  end
endmodule

// File: rtl/gpio3_i2c.sv
module gpio3_i2c
  import gpio3_pkg::*;
#(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned NARROW_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          bus_addr,
  input  logic                bus_we,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [BUS_W-1:0]    pa_in,
  input  logic [BUS_W-1:0]    pb_in,
  input  logic [NARROW_W-1:0] pc_in,
  input  logic                sda_in,
  input  logic                host_sdata_in,
  output logic [BUS_W-1:0]    pa_drive,
  output logic [BUS_W-1:0]    pb_drive,
  output logic [NARROW_W-1:0] pc_drive,
  output logic                host_reset_o,
  output logic                i2c_scl_o,
  output logic                i2c_sda_o
);
  localparam int unsigned NPORT = 3;

  logic      rst_n_int;
  port_sel_e sel;
  logic      is_dir;

  logic [NPORT-1:0][BUS_W-1:0] data_q, dir_q, data_nxt, dir_nxt, ext_in, drive;

  assign sel    = port_sel_e'(bus_addr[1:0]);
  assign is_dir = bus_addr[2];

  gpio3_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam int unsigned PW = (g == NPORT - 1) ? NARROW_W : BUS_W;
    logic [PW-1:0] d_q, r_q, d_n, r_n;
    logic          sel_hit;

    assign sel_hit = bus_we && (sel == port_sel_e'(g));

    gpio3_port_reg #(.W(PW)) i_reg (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .wr_data_en (sel_hit && !is_dir),
      .wr_dir_en  (sel_hit &&  is_dir),
      .wdata      (bus_wdata[PW-1:0]),
      .data_q     (d_q),
      .dir_q      (r_q),
      .data_nxt   (d_n),
      .dir_nxt    (r_n)
    );

    assign data_q[g]   = BUS_W'(d_q);
    assign dir_q[g]    = BUS_W'(r_q);
    assign data_nxt[g] = BUS_W'(d_n);
    assign dir_nxt[g]  = BUS_W'(r_n);
    assign drive[g]    = data_q[g] & dir_q[g];
  end

  // external view of each port, with the fixed and substituted bits of port B
  always_comb begin
    ext_in[PORT_A] = pa_in;
    ext_in[PORT_B] = pb_in;
    ext_in[PORT_B][SUPPLY_BIT] = 1'b1;
    ext_in[PORT_B][SDA_BIT]    = sda_in;
    ext_in[PORT_B][HSDATA_BIT] = host_sdata_in;
    ext_in[PORT_C] = BUS_W'(pc_in);
  end

  gpio3_read_mux #(.NPORT(NPORT), .W(BUS_W)) i_rmux (
    .port_idx (bus_addr[1:0]),
    .is_dir   (is_dir),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .ext_in   (ext_in),
    .rdata    (bus_rdata)
  );

  gpio3_i2c_line #(.W(BUS_W)) i_i2c (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .data_nxt (data_nxt[PORT_B]),
    .dir_nxt  (dir_nxt[PORT_B]),
    .scl      (i2c_scl_o),
    .sda      (i2c_sda_o)
  );

  assign pa_drive     = drive[PORT_A];
  assign pb_drive     = drive[PORT_B];
  assign pc_drive     = drive[PORT_C][NARROW_W-1:0];
  assign host_reset_o = pc_drive[HRST_BIT];
endmodule

// File: rtl/gpio3_i2c_chk.sv
module gpio3_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] pb_drive,
  input logic       host_reset_o,
  input logic       i2c_scl_o,
  input logic       i2c_sda_o
);
  AST_DRIVE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'b101) |=> ((pb_drive & ~$past(bus_wdata)) == 8'h00)); // R2

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({i2c_scl_o, i2c_sda_o}) |-> $past(bus_we && bus_addr[1:0] == 2'b01)); // R3

  AST_SUPPLY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'b101 && !bus_wdata[0]) |=> (bus_addr != 3'b001 || bus_rdata[0])); // R5

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] == 2'b10) |-> (bus_rdata[7:4] == 4'h0)); // R6

  AST_RESET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(host_reset_o) |-> $past(bus_we && bus_addr[1:0] == 2'b10)); // R7

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] == 2'b11) |-> (bus_rdata == 8'h00)); // R8
endmodule

bind gpio3_i2c gpio3_i2c_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .pb_drive     (pb_drive),
  .host_reset_o (host_reset_o),
  .i2c_scl_o    (i2c_scl_o),
  .i2c_sda_o    (i2c_sda_o)
);

// File: tb/test_gpio3_i2c.sv
`timescale 1ns/1ps
module test_gpio3_i2c;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'h3C;
  logic [7:0] pb_in = 8'h00;
  logic [3:0] pc_in = 4'h0;
  logic       sda_in = 1'b1;
  logic       host_sdata_in = 1'b0;
  logic [7:0] pa_drive, pb_drive;
  logic [3:0] pc_drive;
  logic       host_reset_o, i2c_scl_o, i2c_sda_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio3_i2c i_gpio3_i2c (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_in(pa_in), .pb_in(pb_in),
    .pc_in(pc_in), .sda_in(sda_in), .host_sdata_in(host_sdata_in),
    .pa_drive(pa_drive), .pb_drive(pb_drive), .pc_drive(pc_drive),
    .host_reset_o(host_reset_o), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R10 pa_drive", pa_drive, 8'h00);
    check("R10 pb_drive", pb_drive, 8'h00);
    check("R10 pc_drive", {4'h0, pc_drive}, 8'h00);
    check("R10 lines", {6'd0, i2c_scl_o, i2c_sda_o}, 8'h03);
    rd(3'b101, v); check("R10 R9 dir B", v, 8'h00);
    rd(3'b000, v); check("R10 R1 A reads pins", v, 8'h3C);
  endtask

  task automatic t_merge();
    logic [7:0] v;
    wr(3'b000, 8'hA5);
    wr(3'b100, 8'h0F);
    check("R2 pa_drive low nibble", pa_drive, 8'h05);
    rd(3'b000, v); check("R1 merge 0F", v, 8'h35);
    rd(3'b100, v); check("R9 dir A", v, 8'h0F);
    wr(3'b100, 8'hF0);
    check("R2 pa_drive high nibble", pa_drive, 8'hA0);
    rd(3'b000, v); check("R1 merge F0", v, 8'hAC);
  endtask

  task automatic t_i2c();
    wr(3'b001, 8'h00);
    wr(3'b101, 8'h80);
    check("R3 scl low", {6'd0, i2c_scl_o, i2c_sda_o}, 8'h01);
    wr(3'b101, 8'h40);
    check("R3 sda low", {6'd0, i2c_scl_o, i2c_sda_o}, 8'h02);
    wr(3'b101, 8'hC0);
    check("R3 both low", {6'd0, i2c_scl_o, i2c_sda_o}, 8'h00);
    wr(3'b101, 8'h00);
    check("R3 released", {6'd0, i2c_scl_o, i2c_sda_o}, 8'h03);
  endtask

  task automatic t_hold();
    wr(3'b001, 8'h80);
    wr(3'b101, 8'hC0);
    check("R4 hold released", {6'd0, i2c_scl_o, i2c_sda_o}, 8'h03);
    check("R2 pb_drive", pb_drive, 8'h80);
    wr(3'b001, 8'h00);
    check("R3 resume both low", {6'd0, i2c_scl_o, i2c_sda_o}, 8'h00);
    wr(3'b101, 8'h00);
  endtask

  task automatic t_portb_read();
    logic [7:0] v;
    pb_in = 8'h00; sda_in = 1'b1; host_sdata_in = 1'b0;
    rd(3'b001, v); check("R5 sda/supply", v, 8'h41);
    sda_in = 1'b0; host_sdata_in = 1'b1;
    rd(3'b001, v); check("R5 host data", v, 8'h21);
    pb_in = 8'hFF; host_sdata_in = 1'b0;
    rd(3'b001, v); check("R5 pins replaced", v, 8'h9F);
    wr(3'b001, 8'h30);
    wr(3'b101, 8'h30);
    check("R7 host serial clk/data", pb_drive & 8'h30, 8'h30);
    wr(3'b101, 8'h00);
    pb_in = 8'h00; sda_in = 1'b1;
  endtask

  task automatic t_port_c();
    logic [7:0] v;
    wr(3'b010, 8'hFF);
    wr(3'b110, 8'hFF);
    rd(3'b110, v); check("R6 dir C", v, 8'h0F);
    rd(3'b010, v); check("R6 data C", v, 8'h0F);
    check("R6 pc_drive", {4'h0, pc_drive}, 8'h0F);
    check("R7 host reset high", {7'd0, host_reset_o}, 8'h01);
    wr(3'b010, 8'h07);
    check("R7 host reset low", {7'd0, host_reset_o}, 8'h00);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    wr(3'b011, 8'hFF);
    wr(3'b111, 8'hFF);
    rd(3'b011, v); check("R8 unused data", v, 8'h00);
    rd(3'b111, v); check("R8 unused dir", v, 8'h00);
    check("R8 pa_drive kept", pa_drive, 8'hA0);
    check("R8 pb_drive kept", pb_drive, 8'h00);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_merge();
    t_i2c();
    t_hold();
    t_portb_read();
    t_port_c();
    t_unused();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule